// File: doc/BRIEF.md
# Streaming Sample-Driven DFT Accumulator

This block computes an N-point discrete Fourier transform of a real signed sample stream without holding the frame. When a sample is accepted, the block works through the frequency bins one per clock over the next N cycles. For each bin it forms the product of the sample and a fixed-point twiddle factor, adds that product into the bin's complex accumulator, and then drops the sample. A forward/inverse select is captured with each sample and sets the sign of the twiddle's imaginary part for that sample.

When the N-th sample of a frame has updated a bin, the finished bin value leaves on the output stream. In the same cycle the accumulator slot is written with zero instead. The next frame's samples can arrive every N cycles with no gap between frames, so no frame ever has a load phase. The work runs through a four-stage pipeline: twiddle select, multiply, add with saturation, and store/emit.

The point count N must be a power of two (default 64). The accumulator width is a parameter (default 24 bits per real and imaginary part).

Top module: `stream_dft_acc`

## Requirements
- R1: A synchronous reset clears every accumulator, the sample position counter and the pipeline. On the cycle after a reset edge, `bin_valid`, `frame_done` and `smp_overflow` are low. The next accepted sample is position 0 of a fresh frame.
- R2: Forward mode. For sample position n (0-based within the frame) and bin k, let m = (n·k) mod N. Let C(m) = round(256·cos(2πm/N)) and S(m) = round(256·sin(2πm/N)), with halves rounded away from zero. Each forward sample x adds x·C(m) to the real part of bin k and −x·S(m) to its imaginary part.
- R3: When `smp_inverse` is 1 at acceptance, that sample adds +x·S(m) to the imaginary part instead. The select is taken per sample, so one frame may mix the two directions.
- R4: Bins are emitted only after the frame's N-th sample. They come out on N consecutive cycles in index order 0..N−1. Bin k appears 3+k rising edges after the edge that accepted that sample.
- R5: `frame_done` is high exactly on the cycle that carries bin N−1.
- R6: Emitting a bin resets its accumulator to zero, so each frame's result depends only on that frame's samples.
- R7: A new sample may be accepted every N cycles, on the cycle in which the previous sample updates its last bin. Frames can follow each other back to back with no stall and no overflow.
- R8: A valid sample arriving 1 to N−1 cycles after the previous acceptance is dropped. On the next cycle, `smp_overflow` pulses high for one cycle. The dropped sample does not change any result.
- R9: Every accumulator update saturates. Each part clamps to the range −2^(W−1) to 2^(W−1)−1, where W is the accumulator width, and never wraps. Clamping is applied after each single sample's addition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| smp_valid | input | 1 | Sample present this cycle |
| smp_data | input | 8 | Real signed sample |
| smp_inverse | input | 1 | 1 selects the inverse direction for this sample |
| smp_overflow | output | 1 | One-cycle pulse: the previous cycle's sample was dropped |
| bin_valid | output | 1 | A finished bin is on the output |
| bin_index | output | log2(N) | Index of the emitted bin |
| bin_re | output | ACC_W | Real part of the emitted bin, signed |
| bin_im | output | ACC_W | Imaginary part of the emitted bin, signed |
| frame_done | output | 1 | High with the last bin of a frame |

## Verification
Each input pattern targets a specific fault:
- **Impulses at position 0 and at position 3.** The first gives flat spectra. The second rotates through every twiddle index, which exposes errors in the n·k index product.
- **Constant, alternating and period-four inputs.** These concentrate energy in bins 0, N/2 and N/4. A swapped cosine/sine table or a wrong imaginary sign shows up as energy in the wrong bin or a flipped imaginary part.
- **Alternating and mixed-direction frames.** These separate forward from inverse handling, including per-sample capture of the direction bit.
- **Full-scale negative and positive constants.** These drive the accumulators into clamping in the middle of a frame.
- **Overflow and mid-frame reset.** One frame is played with a rejected sample in it, and another follows a reset partway through a frame. Any leakage of dropped or stale data into the result is visible.

// File: rtl/sdft_pkg.sv
package sdft_pkg;

  localparam int SMP_W   = 8;
  localparam int TW_FRAC = 8;
  localparam int TW_W    = TW_FRAC + 2;
  localparam int PROD_W  = SMP_W + TW_W;

  typedef logic signed [SMP_W-1:0]  smp_t;
  typedef logic signed [TW_W-1:0]   tw_t;
  typedef logic signed [PROD_W-1:0] prod_t;

  // Fixed-point twiddle value for angle 2*pi*m/n, rounded half away from zero.
  function automatic int twiddle_fix(input int m, input int n, input bit want_sin);
    real ang;
    real v;
    ang = 2.0 * 3.141592653589793 * m / n;
    v   = want_sin ? $sin(ang) : $cos(ang);
    v   = v * (1 << TW_FRAC);
    return (v >= 0.0) ? $rtoi(v + 0.5) : -$rtoi(0.5 - v);
  endfunction

endpackage

// File: rtl/sdft_seq.sv
module sdft_seq
  import sdft_pkg::*;
#(
  parameter int N    = 64,
  parameter int LOGN = $clog2(N)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            in_valid,
  input  smp_t            in_data,
  input  logic            in_inv,
  output logic            ovf,
  output logic            issue_v,
  output logic [LOGN-1:0] issue_k,
  output logic [LOGN-1:0] issue_n,
  output smp_t            issue_x,
  output logic            issue_inv
);

  localparam logic [LOGN-1:0] KTOP = LOGN'(N - 1);

  logic            busy_q;
  logic [LOGN-1:0] k_q;
  logic [LOGN-1:0] n_q;
  logic [LOGN-1:0] frm_q;
  smp_t            x_q;
  logic            inv_q;

  logic last_slot;
  logic ready;
  logic take;

  assign last_slot = busy_q && (k_q == KTOP);
  assign ready     = !busy_q || last_slot;
  assign take      = in_valid && ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      k_q    <= '0;
      n_q    <= '0;
      frm_q  <= '0;
      x_q    <= '0;
      inv_q  <= 1'b0;
      ovf    <= 1'b0;
    end else begin
      ovf <= in_valid && !ready;
      if (take) begin
        x_q    <= in_data;
        inv_q  <= in_inv;
        n_q    <= frm_q;
        frm_q  <= frm_q + LOGN'(1);
        k_q    <= '0;
        busy_q <= 1'b1;
      end else if (busy_q) begin
        if (last_slot) busy_q <= 1'b0;
        else           k_q    <= k_q + LOGN'(1);
      end
    end
  end

  assign issue_v   = busy_q;
  assign issue_k   = k_q;
  assign issue_n   = n_q;
  assign issue_x   = x_q;
  assign issue_inv = inv_q;

  AST_SAMPLE_HELD: assert property (@(posedge clk) disable iff (rst)
    (busy_q && !last_slot) |=> ($stable(x_q) && $stable(n_q) && $stable(inv_q))); // R8

endmodule

// File: rtl/sdft_aspect.sv
module sdft_aspect
  import sdft_pkg::*;
#(
  parameter int N    = 64,
  parameter int LOGN = $clog2(N)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            issue_v,
  input  logic [LOGN-1:0] issue_k,
  input  logic [LOGN-1:0] issue_n,
  input  smp_t            issue_x,
  input  logic            issue_inv,
  output logic            s1_v,
  output logic [LOGN-1:0] s1_k,
  output logic            s1_last,
  output smp_t            s1_x,
  output logic            s1_inv,
  output tw_t             s1_cos,
  output tw_t             s1_sin
);

  localparam logic [LOGN-1:0] NTOP = LOGN'(N - 1);

  tw_t cos_tab [N];
  tw_t sin_tab [N];

  for (genvar i = 0; i < N; i++) begin : g_tab
    localparam int CV = twiddle_fix(i, N, 1'b0);
    localparam int SV = twiddle_fix(i, N, 1'b1);
    assign cos_tab[i] = tw_t'(CV);
    assign sin_tab[i] = tw_t'(SV);
  end

  // Angle index wraps naturally because N is a power of two.
  logic [LOGN-1:0] ang_idx;
  assign ang_idx = issue_n * issue_k;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_v    <= 1'b0;
      s1_k    <= '0;
      s1_last <= 1'b0;
      s1_x    <= '0;
      s1_inv  <= 1'b0;
      s1_cos  <= '0;
      s1_sin  <= '0;
    end else begin
      s1_v    <= issue_v;
      s1_k    <= issue_k;
      s1_last <= (issue_n == NTOP);
      s1_x    <= issue_x;
      s1_inv  <= issue_inv;
      s1_cos  <= cos_tab[ang_idx];
      s1_sin  <= sin_tab[ang_idx];
    end
  end

endmodule

// File: rtl/sdft_mac.sv
module sdft_mac
  import sdft_pkg::*;
#(
  parameter int N     = 64,
  parameter int LOGN  = $clog2(N),
  parameter int ACC_W = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             s1_v,
  input  logic [LOGN-1:0]  s1_k,
  input  logic             s1_last,
  input  smp_t             s1_x,
  input  logic             s1_inv,
  input  tw_t              s1_cos,
  input  tw_t              s1_sin,
  output logic             bin_valid,
  output logic [LOGN-1:0]  bin_index,
  output logic [ACC_W-1:0] bin_re,
  output logic [ACC_W-1:0] bin_im,
  output logic             frame_done
);

  localparam int SUM_W = ((ACC_W > PROD_W) ? ACC_W : PROD_W) + 1;
  localparam logic [LOGN-1:0] KTOP = LOGN'(N - 1);

  function automatic logic signed [ACC_W-1:0] clamp_acc(input logic signed [SUM_W-1:0] v);
    logic signed [SUM_W-1:0] hi;
    logic signed [SUM_W-1:0] lo;
    hi = $signed(SUM_W'({1'b0, {(ACC_W-1){1'b1}}}));
    lo = -hi - SUM_W'(1);
    if (v > hi)      return hi[ACC_W-1:0];
    else if (v < lo) return lo[ACC_W-1:0];
    else             return v[ACC_W-1:0];
  endfunction

  logic signed [ACC_W-1:0] acc_re [N];
  logic signed [ACC_W-1:0] acc_im [N];

  // Multiply stage
  prod_t mul_re, mul_sn, mul_im;
  assign mul_re = prod_t'(s1_x) * prod_t'(s1_cos);
  assign mul_sn = prod_t'(s1_x) * prod_t'(s1_sin);
  assign mul_im = s1_inv ? mul_sn : -mul_sn;

  logic            s2_v;
  logic [LOGN-1:0] s2_k;
  logic            s2_last;
  prod_t           s2_pr;
  prod_t           s2_pi;

  always_ff @(posedge clk) begin
    if (rst) begin
      s2_v    <= 1'b0;
      s2_k    <= '0;
      s2_last <= 1'b0;
      s2_pr   <= '0;
      s2_pi   <= '0;
    end else begin
      s2_v    <= s1_v;
      s2_k    <= s1_k;
      s2_last <= s1_last;
      s2_pr   <= mul_re;
      s2_pi   <= mul_im;
    end
  end

  // Add stage: each bin is read here exactly once per sample.
  logic signed [SUM_W-1:0]  sum_re, sum_im;
  logic signed [ACC_W-1:0]  sat_re, sat_im;
  assign sum_re = SUM_W'(acc_re[s2_k]) + SUM_W'(s2_pr);
  assign sum_im = SUM_W'(acc_im[s2_k]) + SUM_W'(s2_pi);
  assign sat_re = clamp_acc(sum_re);
  assign sat_im = clamp_acc(sum_im);

  // Store / emit stage
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < N; i++) begin
        acc_re[i] <= '0;
        acc_im[i] <= '0;
      end
      bin_valid  <= 1'b0;
      bin_index  <= '0;
      bin_re     <= '0;
      bin_im     <= '0;
      frame_done <= 1'b0;
    end else begin
      if (s2_v) begin
        acc_re[s2_k] <= s2_last ? '0 : sat_re;
        acc_im[s2_k] <= s2_last ? '0 : sat_im;
      end
      bin_valid  <= s2_v && s2_last;
      bin_index  <= s2_k;
      bin_re     <= sat_re;
      bin_im     <= sat_im;
      frame_done <= s2_v && s2_last && (s2_k == KTOP);
    end
  end

  AST_CLEAR_ON_EMIT: assert property (@(posedge clk) disable iff (rst)
    bin_valid |-> (acc_re[bin_index] == '0 && acc_im[bin_index] == '0)); // R6

  AST_BIN_STEP: assert property (@(posedge clk) disable iff (rst)
    (bin_valid && !frame_done) |=> (bin_valid && bin_index == $past(bin_index) + LOGN'(1))); // R4

  AST_DONE_AT_TOP: assert property (@(posedge clk) disable iff (rst)
    frame_done |-> (bin_valid && bin_index == KTOP)); // R5

  AST_SAT_NO_WRAP: assert property (@(posedge clk) disable iff (rst)
    (s2_v && !s2_last && s2_pr >= 0 && acc_re[s2_k] >= 0) |=> (acc_re[$past(s2_k)] >= 0)); // R9

endmodule

// File: rtl/stream_dft_acc.sv
module stream_dft_acc
  import sdft_pkg::*;
#(
  parameter int N     = 64,
  parameter int ACC_W = 24,
  parameter int LOGN  = $clog2(N)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             smp_valid,
  input  logic [SMP_W-1:0] smp_data,
  input  logic             smp_inverse,
  output logic             smp_overflow,
  output logic             bin_valid,
  output logic [LOGN-1:0]  bin_index,
  output logic [ACC_W-1:0] bin_re,
  output logic [ACC_W-1:0] bin_im,
  output logic             frame_done
);

  logic            issue_v, issue_inv;
  logic [LOGN-1:0] issue_k, issue_n;
  smp_t            issue_x;

  logic            s1_v, s1_last, s1_inv;
  logic [LOGN-1:0] s1_k;
  smp_t            s1_x;
  tw_t             s1_cos, s1_sin;

  sdft_seq #(.N(N), .LOGN(LOGN)) u_seq (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (smp_valid),
    .in_data   (smp_t'(smp_data)),
    .in_inv    (smp_inverse),
    .ovf       (smp_overflow),
    .issue_v   (issue_v),
    .issue_k   (issue_k),
    .issue_n   (issue_n),
    .issue_x   (issue_x),
    .issue_inv (issue_inv)
  );

  sdft_aspect #(.N(N), .LOGN(LOGN)) u_aspect (
    .clk       (clk),
    .rst       (rst),
    .issue_v   (issue_v),
    .issue_k   (issue_k),
    .issue_n   (issue_n),
    .issue_x   (issue_x),
    .issue_inv (issue_inv),
    .s1_v      (s1_v),
    .s1_k      (s1_k),
    .s1_last   (s1_last),
    .s1_x      (s1_x),
    .s1_inv    (s1_inv),
    .s1_cos    (s1_cos),
    .s1_sin    (s1_sin)
  );

  sdft_mac #(.N(N), .LOGN(LOGN), .ACC_W(ACC_W)) u_mac (
    .clk        (clk),
    .rst        (rst),
    .s1_v       (s1_v),
    .s1_k       (s1_k),
    .s1_last    (s1_last),
    .s1_x       (s1_x),
    .s1_inv     (s1_inv),
    .s1_cos     (s1_cos),
    .s1_sin     (s1_sin),
    .bin_valid  (bin_valid),
    .bin_index  (bin_index),
    .bin_re     (bin_re),
    .bin_im     (bin_im),
    .frame_done (frame_done)
  );

  AST_NO_OVF_AFTER_RESET: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (!smp_overflow && !bin_valid && !frame_done)); // R1

endmodule

// File: tb/test_stream_dft_acc.sv
module test_stream_dft_acc;

  localparam int CLK_NS = 10;
  localparam int PTS    = 16;
  localparam int AW     = 16;
  localparam int LG     = $clog2(PTS);
  localparam int NV     = 8;
  localparam int NF     = 10;
  localparam int TOL    = 1;

  typedef struct packed {
    logic [2:0]        kind;   // 0 impulse, 1 constant, 2 alternating, 3 ramp, 4 period-four
    logic [3:0]        pos;
    logic signed [7:0] amp;
    logic [1:0]        dmode;  // 0 forward, 1 inverse, 2 inverse on odd positions
  } vec_t;

  localparam vec_t VEC [NF] = '{
    '{3'd0, 4'd0, 8'sd9,   2'd0},
    '{3'd0, 4'd3, -8'sd5,  2'd0},
    '{3'd1, 4'd0, 8'sd7,   2'd0},
    '{3'd2, 4'd0, 8'sd6,   2'd1},
    '{3'd3, 4'd0, 8'sd1,   2'd0},
    '{3'd4, 4'd0, 8'sd12,  2'd2},
    '{3'd1, 4'd0, 8'h80,   2'd0},
    '{3'd1, 4'd0, 8'sd127, 2'd1},
    '{3'd0, 4'd2, 8'sd11,  2'd0},
    '{3'd0, 4'd1, -8'sd9,  2'd1}
  };

  logic          clk = 1'b0;
  logic          rst;
  logic          smp_valid;
  logic [7:0]    smp_data;
  logic          smp_inverse;
  logic          smp_overflow;
  logic          bin_valid;
  logic [LG-1:0] bin_index;
  logic [AW-1:0] bin_re;
  logic [AW-1:0] bin_im;
  logic          frame_done;

  stream_dft_acc #(.N(PTS), .ACC_W(AW)) i_stream_dft_acc (
    .clk          (clk),
    .rst          (rst),
    .smp_valid    (smp_valid),
    .smp_data     (smp_data),
    .smp_inverse  (smp_inverse),
    .smp_overflow (smp_overflow),
    .bin_valid    (bin_valid),
    .bin_index    (bin_index),
    .bin_re       (bin_re),
    .bin_im       (bin_im),
    .frame_done   (frame_done)
  );

  always #(CLK_NS/2) clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0;
  int fails  = 0;
  int exp_re [NF][PTS];
  int exp_im [NF][PTS];
  int last_acc = 0;
  int mon_f = 0;
  int mon_k = 0;
  int stray_ovf = 0;
  bit ovf_expect = 1'b0;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int tw(input int m, input bit s);
    real a, v;
    a = 2.0 * 3.141592653589793 * real'(m) / real'(PTS);
    v = (s ? $sin(a) : $cos(a)) * 256.0;
    return (v >= 0.0) ? $rtoi(v + 0.5) : -$rtoi(0.5 - v);
  endfunction

  function automatic int sample_of(input int f, input int n);
    int a;
    a = int'(VEC[f].amp);
    case (VEC[f].kind)
      3'd0:    return (n == int'(VEC[f].pos)) ? a : 0;
      3'd1:    return a;
      3'd2:    return (n % 2 == 1) ? -a : a;
      3'd3:    return (n - 8) * a;
      default: return (n % 4 == 0) ? a : ((n % 4 == 2) ? -a : 0);
    endcase
  endfunction

  function automatic bit dir_of(input int f, input int n);
    if (VEC[f].dmode == 2'd0) return 1'b0;
    if (VEC[f].dmode == 2'd1) return 1'b1;
    return (n % 2 == 1);
  endfunction

  function automatic int clampv(input int v);
    int lim;
    lim = 1 << (AW - 1);
    if (v > lim - 1) return lim - 1;
    if (v < -lim)    return -lim;
    return v;
  endfunction

  function automatic string req_of(input int f);
    case (f)
      1:       return "R6";
      3, 5:    return "R3";
      6, 7:    return "R9";
      8:       return "R8";
      9:       return "R1";
      default: return "R2";
    endcase
  endfunction

  initial begin
    for (int f = 0; f < NF; f++) begin
      for (int k = 0; k < PTS; k++) begin
        int re, im;
        re = 0;
        im = 0;
        for (int n = 0; n < PTS; n++) begin
          int m, x, s;
          m  = (n * k) % PTS;
          x  = sample_of(f, n);
          s  = x * tw(m, 1'b1);
          re = clampv(re + x * tw(m, 1'b0));
          im = clampv(im + (dir_of(f, n) ? s : -s));
        end
        exp_re[f][k] = re;
        exp_im[f][k] = im;
      end
    end
  end

  always @(negedge clk) begin
    if (smp_overflow && !ovf_expect) stray_ovf++;
    if (bin_valid) begin
      if (mon_f >= NF) begin
        chk(1'b0, "R4", "bin beyond last frame", int'(bin_index), 0);
      end else begin
        chk(int'(bin_index) == mon_k, "R4", "bin order", int'(bin_index), mon_k);
        chk(cyc == last_acc + 3 + mon_k, "R4", "emit cycle", cyc, last_acc + 3 + mon_k);
        chk(frame_done == (mon_k == PTS - 1), "R5", "frame_done", int'(frame_done), int'(mon_k == PTS - 1));
        begin
          int ar, ai, d1, d2;
          ar = int'($signed(bin_re));
          ai = int'($signed(bin_im));
          d1 = ar - exp_re[mon_f][mon_k];
          d2 = ai - exp_im[mon_f][mon_k];
          chk(d1 <= TOL && d1 >= -TOL, req_of(mon_f), "real part", ar, exp_re[mon_f][mon_k]);
          chk(d2 <= TOL && d2 >= -TOL, req_of(mon_f), "imag part", ai, exp_im[mon_f][mon_k]);
        end
        mon_k++;
        if (mon_k == PTS) begin
          mon_k = 0;
          mon_f++;
        end
      end
    end
  end

  // Plays cnt samples of frame f, one every PTS cycles; rej >= 0 injects a
  // sample that must be dropped during the busy window of position rej.
  task automatic feed(input int f, input int rej, input int cnt);
    for (int n = 0; n < cnt; n++) begin
      @(negedge clk);
      smp_valid   = 1'b1;
      smp_data    = 8'(sample_of(f, n));
      smp_inverse = dir_of(f, n);
      @(negedge clk);
      smp_valid = 1'b0;
      if (n == PTS - 1) last_acc = cyc;
      if (n == rej) begin
        @(negedge clk);
        @(negedge clk);
        chk(smp_overflow == 1'b0, "R8", "overflow before reject", int'(smp_overflow), 0);
        ovf_expect  = 1'b1;
        smp_valid   = 1'b1;
        smp_data    = 8'd100;
        smp_inverse = 1'b0;
        @(negedge clk);
        chk(smp_overflow == 1'b1, "R8", "overflow pulse", int'(smp_overflow), 1);
        smp_valid = 1'b0;
        @(negedge clk);
        chk(smp_overflow == 1'b0, "R8", "overflow single cycle", int'(smp_overflow), 0);
        ovf_expect = 1'b0;
        repeat (PTS - 6) @(negedge clk);
      end else begin
        repeat (PTS - 2) @(negedge clk);
      end
    end
  endtask

  initial begin
    rst         = 1'b1;
    smp_valid   = 1'b0;
    smp_data    = '0;
    smp_inverse = 1'b0;
    repeat (3) @(negedge clk);
    chk(!bin_valid,    "R1", "bin_valid in reset",    int'(bin_valid), 0);
    chk(!frame_done,   "R1", "frame_done in reset",   int'(frame_done), 0);
    chk(!smp_overflow, "R1", "overflow in reset",     int'(smp_overflow), 0);
    rst = 1'b0;

    // Table walk: frames back to back (R7)
    for (int f = 0; f < NV; f++) feed(f, -1, PTS);

    // Dropped sample inside a frame (R8)
    feed(8, 5, PTS);
    repeat (PTS + 8) @(negedge clk);

    // Partial frame, then reset, then a fresh frame (R1)
    feed(2, -1, 5);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    chk(!bin_valid && !frame_done && !smp_overflow, "R1", "outputs after mid-frame reset",
        int'({bin_valid, frame_done, smp_overflow}), 0);
    rst = 1'b0;
    feed(9, -1, PTS);
    repeat (PTS + 8) @(negedge clk);

    chk(mon_f == NF && mon_k == 0, "R4", "frames emitted", mon_f, NF);
    chk(stray_ovf == 0, "R7", "unexpected overflow pulses", stray_ovf, 0);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_NS * 200000);
    checks++;
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule